// File: doc/BRIEF.md
# Validated 16-bit Serial Register Slave

This block is a synchronous-serial slave that lets a host controller reach three small registers: a writable control register, a sticky diagnosis register and a live status register. The host lowers a select line, clocks a 16-bit frame in most significant bit first and raises the select line again. The frame is judged as a whole at that moment. Only a frame with exactly sixteen data-clock falls and a well-formed command is executed. Any other frame is dropped and leaves every register as it was.

Replies lag by one frame. The word that answers frame N is shifted out while frame N+1 is clocked in. Before the first rising data-clock edge of a frame, the serial output shows an attention flag. The flag is raised when the previous frame was rejected or when any latched diagnosis bit is pending. All serial inputs are brought into the system clock with two-flop synchronisers, and their edges are detected in that domain.

The frame engine has three named states. IDLE waits with the output disabled. On a select fall it moves IDLE->SHIFT, loads the reply and drives the flag. SHIFT counts data-clock falls and shifts bits in and out. On a select rise it moves SHIFT->COMMIT. COMMIT lasts one cycle, validates and executes the frame, and then moves COMMIT->IDLE.

Top module: `sreg_spi_slave`

## Requirements
- R1: A frame that does not have exactly 16 data-clock falls while selected is discarded. `ctrl_q` is unchanged and the next reply is 16'h0000.
- R2: Data travels most significant bit first, both in and out.
- R3: `ser_din` is taken on falling `ser_clk` edges. `ser_dout` changes only after a rising `ser_clk` edge or at the start of a frame.
- R4: While `sel_n` is high, `ser_dout_en` is low and `ser_clk` and `ser_din` have no effect.
- R5: After `sel_n` falls, `ser_dout_en` is high and `ser_dout` shows the attention flag until the first rising `ser_clk` edge.
- R6: Frame bits 15:14 select the operation: 00 reads status, 01 reads diagnosis, 10 reads control, 11 writes control. Bits 13:8 must be zero. Any other value makes the frame invalid; it is discarded like R1.
- R7: The reply to a valid frame is sent during the next frame. It is {operation, 6'b0, data byte}. The reply to a rejected frame is 16'h0000.
- R8: The attention flag is 1 when the previous frame was rejected or when any latched diagnosis bit is set. Otherwise it is 0.
- R9: Pulses on `chan_diag` are latched. A valid diagnosis read returns the latched bits in data bits 4:0 and clears them.
- R10: The status byte is sampled at commit. Bit 7 is 0, bit 6 is `wd_timeout`, bit 5 is `wd_ok` and bits 4:0 are `chan_status`.
- R11: After reset, `ctrl_q` is 0, no diagnosis bit is latched, the flag is 0 and the first reply is 16'h0000.
- R12: A valid write-control frame loads bits 7:0 into `ctrl_q`. Its reply data byte is the new control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low frame select from the host |
| ser_clk | input | 1 | Serial data clock from the host |
| ser_din | input | 1 | Serial data into the block |
| ser_dout | output | 1 | Serial reply data; valid only when enabled |
| ser_dout_en | output | 1 | Output enable; low means high impedance |
| chan_status | input | 5 | Live status of the five channels |
| wd_ok | input | 1 | Watchdog status bit |
| wd_timeout | input | 1 | Watchdog time-out bit |
| chan_diag | input | 5 | Diagnosis event pulses of the five channels |
| ctrl_q | output | 8 | Control register contents |

## Verification
The assertions assume that `ser_clk` is low whenever `sel_n` changes. They also assume that each data-clock phase and each gap between frames lasts several system clocks, so that every edge reaches the synchronised domain as a separate event. The diagnosis-clear check also takes for granted that no new diagnosis pulse arrives in the commit cycle it observes. The stimulus holds each data-clock phase for eight system clocks and leaves idle gaps between frames. It changes the status inputs and fires diagnosis pulses only while no frame is in flight.

// File: rtl/sreg_spi_pkg.sv
package sreg_spi_pkg;
    typedef enum logic [1:0] {
        OP_RD_STAT = 2'b00,
        OP_RD_DIAG = 2'b01,
        OP_RD_CTRL = 2'b10,
        OP_WR_CTRL = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_COMMIT
    } frame_st_e;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sreg_frame_fsm.sv
module sreg_frame_fsm
    import sreg_spi_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    localparam int CNT_W     = $clog2(FRAME_BITS) + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_s,
    input  logic                  sclk_s,
    input  logic                  din_s,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  flag,
    output logic                  dout_q,
    output logic                  dout_en,
    output logic                  commit,
    output logic                  len_ok,
    output logic [FRAME_BITS-1:0] rx_word
);
    frame_st_e             state, state_nx;
    logic                  sel_d, sclk_d;
    logic                  cs_fall, cs_rise, sclk_rise, sclk_fall;
    logic [FRAME_BITS-1:0] tx_sh;
    logic [CNT_W-1:0]      bit_cnt;

    assign cs_fall   = sel_d & ~sel_s;
    assign cs_rise   = ~sel_d & sel_s;
    assign sclk_rise = ~sclk_d & sclk_s;
    assign sclk_fall = sclk_d & ~sclk_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            sel_d  <= sel_s;
            sclk_d <= sclk_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (cs_fall) state_nx = ST_SHIFT;
            ST_SHIFT:  if (cs_rise) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= 1'b1;
            dout_en <= 1'b0;
            tx_sh   <= '0;
            rx_word <= '0;
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        dout_en <= 1'b1;
                        dout_q  <= flag;
                        tx_sh   <= tx_word;
                        bit_cnt <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (cs_rise) begin
                        dout_en <= 1'b0;
                    end else begin
                        if (sclk_rise) begin
                            dout_q <= tx_sh[FRAME_BITS-1];
                            tx_sh  <= {tx_sh[FRAME_BITS-2:0], 1'b0};
                        end
                        if (sclk_fall) begin
                            rx_word <= {rx_word[FRAME_BITS-2:0], din_s};
                            if (bit_cnt != '1) bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_COMMIT: ;
                default: dout_en <= 1'b0;
            endcase
        end
    end

    assign commit = (state == ST_COMMIT);
    assign len_ok = (bit_cnt == CNT_W'(FRAME_BITS));

    // R4
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && $past(sel_s)) |-> !dout_en);

    // R3
    so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past(sclk_rise || cs_fall));
endmodule

// File: rtl/sreg_regbank.sv
module sreg_regbank
    import sreg_spi_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CHANS      = 5,
    parameter int CTRL_W     = 8,
    localparam int RESV_W    = FRAME_BITS - 2 - CTRL_W,
    localparam int PAD_W     = CTRL_W - CHANS - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic                  len_ok,
    input  logic [FRAME_BITS-1:0] rx_word,
    input  logic [CHANS-1:0]      chan_status,
    input  logic                  wd_ok,
    input  logic                  wd_timeout,
    input  logic [CHANS-1:0]      chan_diag,
    output logic [CTRL_W-1:0]     ctrl_q,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic                  flag
);
    op_e               op;
    logic [RESV_W-1:0] resv;
    logic [CTRL_W-1:0] wdata, rdata;
    logic [CHANS-1:0]  diag_lat;
    logic              err_q, exec_ok, reject, wr_exec, clr_diag;

    assign op       = op_e'(rx_word[FRAME_BITS-1 -: 2]);
    assign resv     = rx_word[FRAME_BITS-3 -: RESV_W];
    assign wdata    = rx_word[CTRL_W-1:0];
    assign exec_ok  = commit && len_ok && (resv == '0);
    assign reject   = commit && !(len_ok && (resv == '0));
    assign wr_exec  = exec_ok && (op == OP_WR_CTRL);
    assign clr_diag = exec_ok && (op == OP_RD_DIAG);

    always_comb begin
        unique case (op)
            OP_RD_STAT: rdata = {{PAD_W{1'b0}}, wd_timeout, wd_ok, chan_status};
            OP_RD_DIAG: rdata = CTRL_W'(diag_lat);
            OP_RD_CTRL: rdata = ctrl_q;
            OP_WR_CTRL: rdata = wdata;
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            diag_lat <= '0;
            err_q    <= 1'b0;
            tx_word  <= '0;
        end else begin
            diag_lat <= (clr_diag ? '0 : diag_lat) | chan_diag;
            if (wr_exec) ctrl_q <= wdata;
            if (exec_ok) begin
                err_q   <= 1'b0;
                tx_word <= {op, {RESV_W{1'b0}}, rdata};
            end else if (reject) begin
                err_q   <= 1'b1;
                tx_word <= '0;
            end
        end
    end

    assign flag = err_q | (|diag_lat);

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_exec |=> $stable(ctrl_q));

    // R9
    diag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_diag && chan_diag == '0) |=> (diag_lat == '0));

    // R8
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> flag);
endmodule

// File: rtl/sreg_spi_slave.sv
module sreg_spi_slave #(
    parameter int FRAME_BITS  = 16,
    parameter int CHANS       = 5,
    parameter int CTRL_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic              ser_dout_en,
    input  logic [CHANS-1:0]  chan_status,
    input  logic              wd_ok,
    input  logic              wd_timeout,
    input  logic [CHANS-1:0]  chan_diag,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic [2:0]            pins_s;
    logic [FRAME_BITS-1:0] tx_word, rx_word;
    logic                  flag, commit, len_ok;

    sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sel_n, ser_clk, ser_din}),
        .q     (pins_s)
    );

    sreg_frame_fsm #(.FRAME_BITS(FRAME_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_s   (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .din_s   (pins_s[0]),
        .tx_word (tx_word),
        .flag    (flag),
        .dout_q  (ser_dout),
        .dout_en (ser_dout_en),
        .commit  (commit),
        .len_ok  (len_ok),
        .rx_word (rx_word)
    );

    sreg_regbank #(.FRAME_BITS(FRAME_BITS), .CHANS(CHANS), .CTRL_W(CTRL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .len_ok      (len_ok),
        .rx_word     (rx_word),
        .chan_status (chan_status),
        .wd_ok       (wd_ok),
        .wd_timeout  (wd_timeout),
        .chan_diag   (chan_diag),
        .ctrl_q      (ctrl_q),
        .tx_word     (tx_word),
        .flag        (flag)
    );
endmodule

// File: tb/sreg_spi_slave_bench.sv
module sreg_spi_slave_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
    logic       ser_dout, ser_dout_en;
    logic [4:0] chan_status = '0, chan_diag = '0;
    logic       wd_ok = 1'b0, wd_timeout = 1'b0;
    logic [7:0] ctrl_q;

    int vectors = 0, errors = 0;
    logic [7:0]  m_ctrl = '0;
    logic [4:0]  m_diag = '0;
    logic        m_err = 1'b0;
    logic [15:0] m_resp = '0;

    always #2 clk = ~clk;

    sreg_spi_slave u_sreg_spi_slave (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .chan_status(chan_status),
        .wd_ok(wd_ok), .wd_timeout(wd_timeout), .chan_diag(chan_diag), .ctrl_q(ctrl_q)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] expect_reply(input logic [15:0] w, input logic [7:0] cur_ctrl,
                                                 input logic [4:0] dl);
        logic [7:0] d;
        case (w[15:14])
            2'b00:   d = {1'b0, wd_timeout, wd_ok, chan_status};
            2'b01:   d = {3'b000, dl};
            2'b10:   d = cur_ctrl;
            default: d = w[7:0];
        endcase
        return {w[15:14], 6'b0, d};
    endfunction

    // Sends one frame of nbits data clocks; checks the flag, the reply and the after-effects.
    task automatic frame(input logic [15:0] w, input int nbits);
        logic [15:0] got = '0;
        logic        valid;
        @(negedge clk) sel_n = 1'b0;
        wait_clks(8);
        check("R5 output enabled", {15'b0, ser_dout_en}, 16'h1);
        check("R5 R8 attention flag", {15'b0, ser_dout}, {15'b0, m_err | (|m_diag)});
        for (int i = 0; i < nbits; i++) begin
            ser_din = w[15 - (i % 16)];
            ser_clk = 1'b1;
            wait_clks(8);
            got = {got[14:0], ser_dout};
            ser_clk = 1'b0;
            wait_clks(8);
        end
        if (nbits == 16) check("R2 R3 R7 reply word", got, m_resp);
        sel_n = 1'b1;
        wait_clks(10);
        check("R4 output disabled", {15'b0, ser_dout_en}, 16'h0);
        valid = (nbits == 16) && (w[13:8] == 6'b0);
        if (valid) begin
            m_resp = expect_reply(w, m_ctrl, m_diag);
            if (w[15:14] == 2'b11) m_ctrl = w[7:0];
            if (w[15:14] == 2'b01) m_diag = '0;
            m_err = 1'b0;
        end else begin
            m_resp = '0;
            m_err  = 1'b1;
        end
        check(valid ? "R12 control value" : "R1 R6 control unchanged", {8'b0, ctrl_q}, {8'b0, m_ctrl});
        wait_clks(4);
    endtask

    task automatic diag_pulse(input logic [4:0] v);
        @(negedge clk) chan_diag = v;
        @(negedge clk) chan_diag = '0;
        m_diag = m_diag | v;
        wait_clks(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        // R11 reset state
        check("R11 control reset", {8'b0, ctrl_q}, 16'h0);
        check("R11 R4 output disabled at reset", {15'b0, ser_dout_en}, 16'h0);
        // R11 first reply is zero, flag clear; R10 status layout
        chan_status = 5'b10110; wd_ok = 1'b1; wd_timeout = 1'b0;
        frame(16'h0000, 16);
        frame(16'hC0A5, 16);       // R12 write control
        frame(16'h8000, 16);       // reply echoes A5
        frame(16'h0000, 16);       // control read reply
        // R1 short and long frames
        frame(16'hC03C, 15);
        frame(16'hC03C, 17);
        frame(16'h8000, 16);       // flag set, reply zero
        // R6 reserved bits non-zero
        frame(16'hC13C, 16);
        frame(16'h8000, 16);
        // R4 clock and data toggles while deselected have no effect
        for (int i = 0; i < 20; i++) begin
            @(negedge clk) ser_clk = ~ser_clk; ser_din = i[0];
            wait_clks(3);
            check("R4 idle toggles keep output off", {15'b0, ser_dout_en}, 16'h0);
        end
        ser_clk = 1'b0;
        wait_clks(4);
        frame(16'h8000, 16);
        // R9 diagnosis latch and clear on read
        diag_pulse(5'b00101);
        diag_pulse(5'b10000);
        frame(16'h4000, 16);
        frame(16'h0000, 16);       // reply carries 10101, flag now clear
        frame(16'h0000, 16);
        // Constrained random frames
        for (int n = 0; n < 200; n++) begin
            logic [15:0] w;
            int          nb;
            w = 16'($urandom());
            if ($urandom_range(9) != 0) w[13:8] = 6'b0;
            nb = ($urandom_range(7) == 0) ? int'($urandom_range(20, 1)) : 16;
            if ($urandom_range(5) == 0) diag_pulse(5'($urandom()));
            chan_status = 5'($urandom());
            wd_ok = 1'($urandom());
            wd_timeout = 1'($urandom());
            wait_clks(2);
            frame(w, nb);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule